// File: doc/BRIEF.md
# Pulse Attempt Sequencer

This block runs an unattended campaign of timed-pulse test attempts against a target device that boots from external serial flash. Each attempt powers the target, lets it boot from the first of two flash devices, and watches the serial flash bus for read commands. When a configured number of reads has been seen, it moves the target's chip-select over to the second flash device. It waits a programmable delay, fires one output pulse of programmable width, and then keeps watching the bus. The next read address decides the outcome. A read at the expected address ends the campaign with a sticky success flag and leaves the target running. Any other read, or a wait that runs out, cuts the supply and starts a fresh attempt.

A host writes the thresholds, delays, widths and the expected address through a small register port and reads back an attempt count and the success flag. The target's serial clock, data line and chip-select are oversampled in the block's clock domain. The target's chip-select is forwarded combinationally to whichever flash device is selected, and the selection only changes while the chip-select is idle.

Top module: `pulse_attempt_seq`

## Requirements
- R1: After reset the supply enable, run line, boot-select line and pulse output are low, both flash chip-selects are high, and the status register reads 0.
- R2: Registers read back as written, at `cfg_addr` 0 control (bit0 enable, bit1 clear strobe that reads back 0, bit2 boot-select level), 1 power-off time, 2 trigger read count, 3 pulse delay, 4 pulse width, 5 expected address (24 bits), 6 watchdog timeout, 7 status (bit0 success, bits 15:1 attempt count).
- R3: After enable is set, supply and run stay low for the power-off time (values below 1 act as 1) plus at most two cycles, then rise together; run is never high while the supply is off.
- R4: At most one flash chip-select is low at any time; while flash 0 is selected, `flash_cs_n[0]` follows `tgt_cs_n` and `flash_cs_n[1]` stays high.
- R5: A read is a transaction whose first 32 bits are sampled from `tgt_io0` on `tgt_sck` rising edges, most significant bit first, as an 8-bit opcode equal to 0x03 followed by a 24-bit address; other opcodes are not counted.
- R6: After the trigger-count-th read of an attempt (values below 1 act as 1), the selection moves to flash 1, and it changes only while `tgt_cs_n` is high.
- R7: After the switch, the pulse rises between D+1 and D+5 cycles after `tgt_cs_n` rises, where D is the delay. It stays high for exactly the width (values below 1 act as 1), and at most one pulse occurs per power-on.
- R8: A read after the pulse at an address other than the expected one switches the supply off; the next attempt starts on flash 0 and the attempt count increments when the supply comes back.
- R9: A read after the pulse at the expected address sets the success flag; the supply stays on, and later reads cause neither a pulse nor a power cycle.
- R10: While waiting for reads before the switch, for an idle chip-select, or for the outcome read, the timeout count of cycles without the awaited event switches the supply off and starts a new attempt.
- R11: Clearing enable switches the supply off within two cycles.
- R12: Writing control with bit1 set clears the attempt count and the success flag.
- R13: `tgt_boot_sel` equals control bit2 while the supply is on and is low while it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| tgt_cs_n | input | 1 | Chip-select driven by the target |
| tgt_sck | input | 1 | Serial clock driven by the target |
| tgt_io0 | input | 1 | Serial command/address line from the target |
| flash_cs_n | output | 2 | Chip-selects to flash device 0 and 1 |
| tgt_pwr_en | output | 1 | Target supply enable |
| tgt_run | output | 1 | Target run line (held low while unpowered) |
| tgt_boot_sel | output | 1 | Target boot-select line |
| pulse_out | output | 1 | Trigger to the external pulse source |

## Verification
The bench drives whole serial transactions: plain reads at varied addresses, a fast-read opcode, a status-style opcode and reads at the expected address. Among them, the non-read opcode shows that only the 0x03 opcode advances the trigger count. Routing is observed on both flash chip-selects during each transaction, which tells a switch before the trigger apart from one after it and shows that a failed attempt returns to flash 0. A wrong-address read, a matching read and a run with no bus activity at all separate the three outcomes: power-cycle, sticky success and watchdog expiry, each with its own attempt count.

// File: rtl/pas_pkg.sv
package pas_pkg;

  localparam int unsigned CW     = 32;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_OFF  = 3'd1;
  localparam logic [REG_AW-1:0] RA_TRIG = 3'd2;
  localparam logic [REG_AW-1:0] RA_DLY  = 3'd3;
  localparam logic [REG_AW-1:0] RA_WID  = 3'd4;
  localparam logic [REG_AW-1:0] RA_OK   = 3'd5;
  localparam logic [REG_AW-1:0] RA_TMO  = 3'd6;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OFF, ST_BOOT, ST_ARM, ST_DELAY, ST_PULSE, ST_WATCH, ST_DONE
  } seq_state_t;

  // Zero in a count register behaves as one.
  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  // True on the last cycle of a window of `limit` cycles started at t=0.
  function automatic logic timer_done(input logic [CW-1:0] t, input logic [CW-1:0] limit);
    return (t + CW'(1)) >= at_least_one(limit);
  endfunction

endpackage

// File: rtl/pas_spi_monitor.sv
module pas_spi_monitor #(
  parameter int unsigned ADDR_W  = 24,
  parameter logic [7:0]  READ_OP = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              io,
  output logic              rd_evt,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cs_q
);
  localparam int unsigned WORD_W = 8 + ADDR_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic              sck_q, sck_p, io_q;
  logic [CNT_W-1:0]  nbits;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;
  logic              sck_rise;

  assign sck_rise  = sck_q && !sck_p;
  assign next_word = {shreg[WORD_W-2:0], io_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      sck_p   <= 1'b0;
      io_q    <= 1'b0;
      nbits   <= '0;
      shreg   <= '0;
      rd_evt  <= 1'b0;
      rd_addr <= '0;
    end else begin
      cs_q   <= cs_n;
      sck_q  <= sck;
      sck_p  <= sck_q;
      io_q   <= io;
      rd_evt <= 1'b0;
      if (cs_q) begin
        nbits <= '0;
      end else if (sck_rise && (nbits < CNT_W'(WORD_W))) begin
        shreg <= next_word;
        nbits <= nbits + CNT_W'(1);
        if ((nbits == CNT_W'(WORD_W - 1)) && (next_word[WORD_W-1 -: 8] == READ_OP)) begin
          rd_evt  <= 1'b1;
          rd_addr <= next_word[ADDR_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pas_cfg_regs.sv
module pas_cfg_regs import pas_pkg::*; #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned ATT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [CW-1:0]     wdata,
  input  logic [ATT_W-1:0]  attempts,
  input  logic              success,
  output logic [CW-1:0]     rdata,
  output logic              en,
  output logic              clr,
  output logic              boot_lvl,
  output logic [CW-1:0]     off_time,
  output logic [CW-1:0]     trig_cnt,
  output logic [CW-1:0]     dly,
  output logic [CW-1:0]     wid,
  output logic [ADDR_W-1:0] ok_addr,
  output logic [CW-1:0]     tmo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      clr      <= 1'b0;
      boot_lvl <= 1'b0;
      off_time <= CW'(16);
      trig_cnt <= CW'(1);
      dly      <= '0;
      wid      <= CW'(1);
      ok_addr  <= '0;
      tmo      <= CW'(4096);
    end else begin
      clr <= we && (addr == RA_CTRL) && wdata[1];
      if (we) begin
        case (addr)
          RA_CTRL: begin en <= wdata[0]; boot_lvl <= wdata[2]; end
          RA_OFF:  off_time <= wdata;
          RA_TRIG: trig_cnt <= wdata;
          RA_DLY:  dly      <= wdata;
          RA_WID:  wid      <= wdata;
          RA_OK:   ok_addr  <= wdata[ADDR_W-1:0];
          RA_TMO:  tmo      <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = CW'({boot_lvl, 1'b0, en});
      RA_OFF:  rdata = off_time;
      RA_TRIG: rdata = trig_cnt;
      RA_DLY:  rdata = dly;
      RA_WID:  rdata = wid;
      RA_OK:   rdata = CW'(ok_addr);
      RA_TMO:  rdata = tmo;
      default: rdata = CW'({attempts, success});
    endcase
  end
endmodule

// File: rtl/pas_attempt_fsm.sv
module pas_attempt_fsm import pas_pkg::*; #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned ATT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [CW-1:0]     off_time,
  input  logic [CW-1:0]     trig_cnt,
  input  logic [CW-1:0]     dly,
  input  logic [CW-1:0]     wid,
  input  logic [ADDR_W-1:0] ok_addr,
  input  logic [CW-1:0]     tmo,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cs_idle,
  output logic              pwr_on,
  output logic              sel,
  output logic              pulse,
  output logic [ATT_W-1:0]  attempts,
  output logic              success
);
  seq_state_t    st;
  logic [CW-1:0] tmr;
  logic [CW-1:0] nreads;
  logic          wd_expired;

  assign wd_expired = timer_done(tmr, tmo);
  assign pwr_on = (st == ST_BOOT) || (st == ST_ARM) || (st == ST_DELAY) ||
                  (st == ST_PULSE) || (st == ST_WATCH) || (st == ST_DONE);
  assign pulse  = (st == ST_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      nreads   <= '0;
      sel      <= 1'b0;
      attempts <= '0;
      success  <= 1'b0;
    end else begin
      if (clr) begin
        attempts <= '0;
        success  <= 1'b0;
      end
      tmr <= tmr + CW'(1);
      case (st)
        ST_IDLE: begin
          if (cs_idle) sel <= 1'b0;
          if (en) begin st <= ST_OFF; tmr <= '0; end
        end
        ST_OFF: begin
          if (cs_idle) sel <= 1'b0;
          if (timer_done(tmr, off_time) && !sel) begin
            st       <= ST_BOOT;
            tmr      <= '0;
            nreads   <= '0;
            attempts <= attempts + ATT_W'(1);
          end
        end
        ST_BOOT: begin
          if (rd_evt) begin
            nreads <= nreads + CW'(1);
            if ((nreads + CW'(1)) >= at_least_one(trig_cnt)) begin
              st <= ST_ARM; tmr <= '0;
            end
          end else if (wd_expired) begin
            st <= ST_OFF; tmr <= '0;
          end
        end
        ST_ARM: begin
          if (cs_idle) begin
            sel <= 1'b1; st <= ST_DELAY; tmr <= '0;
          end else if (wd_expired) begin
            st <= ST_OFF; tmr <= '0;
          end
        end
        ST_DELAY: begin
          if (tmr >= dly) begin st <= ST_PULSE; tmr <= '0; end
        end
        ST_PULSE: begin
          if (timer_done(tmr, wid)) begin st <= ST_WATCH; tmr <= '0; end
        end
        ST_WATCH: begin
          if (rd_evt) begin
            if (rd_addr == ok_addr) begin
              st <= ST_DONE; success <= 1'b1;
            end else begin
              st <= ST_OFF; tmr <= '0;
            end
          end else if (wd_expired) begin
            st <= ST_OFF; tmr <= '0;
          end
        end
        default: ;
      endcase
      if (!en) st <= ST_IDLE;
    end
  end
endmodule

// File: rtl/pulse_attempt_seq.sv
module pulse_attempt_seq import pas_pkg::*; #(
  parameter int unsigned ADDR_W  = 24,
  parameter logic [7:0]  READ_OP = 8'h03,
  parameter int unsigned ATT_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [CW-1:0]     cfg_rdata,
  input  logic              tgt_cs_n,
  input  logic              tgt_sck,
  input  logic              tgt_io0,
  output logic [1:0]        flash_cs_n,
  output logic              tgt_pwr_en,
  output logic              tgt_run,
  output logic              tgt_boot_sel,
  output logic              pulse_out
);
  logic              en, clr, boot_lvl;
  logic [CW-1:0]     off_time, trig_cnt, dly, wid, tmo;
  logic [ADDR_W-1:0] ok_addr;
  logic [ATT_W-1:0]  attempts;
  logic              success;
  logic              rd_evt;
  logic [ADDR_W-1:0] rd_addr;
  logic              cs_q;
  logic              cs_idle;
  logic              flash_sel;
  logic              pwr_on;

  pas_cfg_regs #(.ADDR_W(ADDR_W), .ATT_W(ATT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .attempts(attempts), .success(success), .rdata(cfg_rdata),
    .en(en), .clr(clr), .boot_lvl(boot_lvl), .off_time(off_time),
    .trig_cnt(trig_cnt), .dly(dly), .wid(wid), .ok_addr(ok_addr), .tmo(tmo)
  );

  pas_spi_monitor #(.ADDR_W(ADDR_W), .READ_OP(READ_OP)) u_mon (
    .clk(clk), .rst_n(rst_n), .cs_n(tgt_cs_n), .sck(tgt_sck), .io(tgt_io0),
    .rd_evt(rd_evt), .rd_addr(rd_addr), .cs_q(cs_q)
  );

  // Switching is allowed only when both the sampled and the live chip-select are idle.
  assign cs_idle = cs_q && tgt_cs_n;

  pas_attempt_fsm #(.ADDR_W(ADDR_W), .ATT_W(ATT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .off_time(off_time),
    .trig_cnt(trig_cnt), .dly(dly), .wid(wid), .ok_addr(ok_addr), .tmo(tmo),
    .rd_evt(rd_evt), .rd_addr(rd_addr), .cs_idle(cs_idle),
    .pwr_on(pwr_on), .sel(flash_sel), .pulse(pulse_out),
    .attempts(attempts), .success(success)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_route
      assign flash_cs_n[g] = (flash_sel == g[0]) ? tgt_cs_n : 1'b1;
    end
  endgenerate

  assign tgt_pwr_en   = pwr_on;
  assign tgt_run      = pwr_on;
  assign tgt_boot_sel = pwr_on && boot_lvl;
endmodule

// File: rtl/pas_checker.sv
module pas_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_cs_n,
  input logic [1:0] flash_cs_n,
  input logic       pwr_en,
  input logic       run,
  input logic       pulse,
  input logic       sel
);
  logic       pulse_d;
  logic [1:0] n_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_d <= 1'b0;
      n_pulse <= '0;
    end else begin
      pulse_d <= pulse;
      if (!pwr_en) n_pulse <= '0;
      else if (pulse && !pulse_d && n_pulse != 2'd3) n_pulse <= n_pulse + 2'd1;
    end
  end

  a_r3_run_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pwr_en);

  a_r4_one_flash_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~flash_cs_n) <= 1);

  a_r6_switch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(tgt_cs_n));

  a_r7_pulse_powered: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> pwr_en);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    n_pulse <= 2'd1);

  a_r8_boot_on_flash0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (flash_cs_n[1] && !sel));
endmodule

bind pulse_attempt_seq pas_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_cs_n(tgt_cs_n), .flash_cs_n(flash_cs_n),
  .pwr_en(tgt_pwr_en), .run(tgt_run), .pulse(pulse_out), .sel(flash_sel)
);

// File: tb/pulse_attempt_seq_test.sv
module pulse_attempt_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tgt_cs_n, tgt_sck, tgt_io0;
  logic [1:0]  flash_cs_n;
  logic        tgt_pwr_en, tgt_run, tgt_boot_sel, pulse_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int pulse_cyc = 0;
  int pulse_rises = 0;
  int t_pulse = 0;
  int t_cs_rise = 0;
  logic pulse_prev = 1'b0;
  logic saw0, saw1;
  logic [31:0] rd;

  localparam int OFF_T = 10;
  localparam int TRIG  = 3;
  localparam int DLY   = 20;
  localparam int WID   = 5;
  localparam logic [23:0] OKA = 24'h001234;
  localparam int TMO   = 2000;
  localparam int TMO2  = 300;

  always #4 clk = ~clk;

  pulse_attempt_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tgt_cs_n(tgt_cs_n),
    .tgt_sck(tgt_sck), .tgt_io0(tgt_io0), .flash_cs_n(flash_cs_n),
    .tgt_pwr_en(tgt_pwr_en), .tgt_run(tgt_run), .tgt_boot_sel(tgt_boot_sel),
    .pulse_out(pulse_out)
  );

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    if (pulse_out) begin
      pulse_cyc = pulse_cyc + 1;
      if (!pulse_prev) begin pulse_rises = pulse_rises + 1; t_pulse = cyc; end
    end
    pulse_prev = pulse_out;
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic spi_xfer(input logic [7:0] op, input logic [23:0] adr);
    logic [31:0] w;
    w = {op, adr};
    saw0 = 1'b0; saw1 = 1'b0;
    @(negedge clk);
    tgt_cs_n = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      tgt_io0 = w[i]; tgt_sck = 1'b0;
      repeat (2) begin
        @(negedge clk);
        if (!flash_cs_n[0]) saw0 = 1'b1;
        if (!flash_cs_n[1]) saw1 = 1'b1;
      end
      tgt_sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    tgt_sck = 1'b0;
    @(negedge clk);
    tgt_cs_n = 1'b1;
    t_cs_rise = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_power(input logic lvl, input int limit);
    for (int n = 0; n < limit && tgt_pwr_en != lvl; n++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tgt_cs_n = 1'b1; tgt_sck = 1'b0; tgt_io0 = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!tgt_pwr_en && !tgt_run && !tgt_boot_sel && !pulse_out, "R1 outputs low",
          {tgt_pwr_en, tgt_run, tgt_boot_sel, pulse_out}, 0);
    check(flash_cs_n == 2'b11, "R1 flash cs high", flash_cs_n, 3);
    reg_rd(3'd7, rd);
    check(rd == 0, "R1 status", rd, 0);

    // R2 register readback
    reg_wr(3'd1, OFF_T); reg_wr(3'd2, TRIG); reg_wr(3'd3, DLY);
    reg_wr(3'd4, WID);   reg_wr(3'd5, {8'hAB, OKA}); reg_wr(3'd6, TMO);
    reg_rd(3'd1, rd); check(rd == OFF_T, "R2 off time", rd, OFF_T);
    reg_rd(3'd2, rd); check(rd == TRIG, "R2 trigger count", rd, TRIG);
    reg_rd(3'd3, rd); check(rd == DLY, "R2 delay", rd, DLY);
    reg_rd(3'd4, rd); check(rd == WID, "R2 width", rd, WID);
    reg_rd(3'd5, rd); check(rd == {8'h00, OKA}, "R2 expected address", rd, OKA);
    reg_rd(3'd6, rd); check(rd == TMO, "R2 timeout", rd, TMO);

    // R3 power-off time, R13 boot select
    reg_wr(3'd0, 32'd5);
    reg_rd(3'd0, rd); check(rd == 32'd5, "R2 control (clear reads 0)", rd, 5);
    n = 1;
    while (!tgt_pwr_en && n < 1000) begin @(negedge clk); n++; end
    check(n >= OFF_T && n <= OFF_T + 3, "R3 off interval", n, OFF_T + 1);
    check(tgt_run && tgt_pwr_en, "R3 run with supply", tgt_run, 1);
    check(tgt_boot_sel, "R13 boot select level", tgt_boot_sel, 1);

    // Attempt 1: R4 routing, R5 opcode filter
    spi_xfer(8'h03, 24'h000100);
    check(saw0 && !saw1, "R4 flash0 routing", {saw1, saw0}, 1);
    spi_xfer(8'h0B, 24'h000200);
    spi_xfer(8'h03, 24'h000300);
    repeat (40) @(negedge clk);
    check(pulse_rises == 0, "R5 fast-read not counted (no pulse)", pulse_rises, 0);
    spi_xfer(8'h03, 24'h000400);
    check(saw0 && !saw1, "R5 third read still on flash0", {saw1, saw0}, 1);
    repeat (60) @(negedge clk);
    check(pulse_rises == 1, "R7 one pulse", pulse_rises, 1);
    check(pulse_cyc == WID, "R7 pulse width", pulse_cyc, WID);
    check((t_pulse - t_cs_rise) >= DLY + 1 && (t_pulse - t_cs_rise) <= DLY + 5,
          "R7 pulse delay", t_pulse - t_cs_rise, DLY + 3);
    spi_xfer(8'h05, 24'h000000);
    check(saw1 && !saw0, "R6 routed to flash1 after trigger", {saw1, saw0}, 2);

    // R8 wrong address -> power cycle
    spi_xfer(8'h03, 24'h000999);
    check(!tgt_pwr_en, "R8 supply off after wrong read", tgt_pwr_en, 0);
    wait_power(1'b1, 1000);
    reg_rd(3'd7, rd);
    check(rd[15:1] == 2 && !rd[0], "R8 attempt count", rd[15:1], 2);
    spi_xfer(8'h03, 24'h000100);
    check(saw0 && !saw1, "R8 new attempt on flash0", {saw1, saw0}, 1);
    spi_xfer(8'h03, 24'h000101);
    spi_xfer(8'h03, 24'h000102);
    repeat (60) @(negedge clk);
    check(pulse_rises == 2, "R7 one pulse per attempt", pulse_rises, 2);

    // R9 success
    spi_xfer(8'h03, OKA);
    reg_rd(3'd7, rd);
    check(rd[0] && rd[15:1] == 2, "R9 success flag", rd, 5);
    repeat (60) @(negedge clk);
    spi_xfer(8'h03, 24'h000055);
    spi_xfer(8'h03, OKA);
    check(tgt_pwr_en && pulse_rises == 2, "R9 stays on, no new pulse", pulse_rises, 2);

    // R11 disable
    reg_wr(3'd0, 32'd4);
    repeat (2) @(negedge clk);
    check(!tgt_pwr_en && !tgt_boot_sel, "R11 disable powers off", tgt_pwr_en, 0);
    check(!tgt_boot_sel, "R13 boot select low when off", tgt_boot_sel, 0);

    // R12 clear
    reg_wr(3'd0, 32'd2);
    reg_rd(3'd7, rd);
    check(rd == 0, "R12 clear status", rd, 0);

    // R10 watchdog with no bus activity
    reg_wr(3'd6, TMO2);
    reg_wr(3'd0, 32'd1);
    wait_power(1'b1, 1000);
    n = 0;
    while (tgt_pwr_en && n < 5000) begin n++; @(negedge clk); end
    check(n >= TMO2 - 1 && n <= TMO2 + 2, "R10 watchdog interval", n, TMO2);
    wait_power(1'b1, 1000);
    reg_rd(3'd7, rd);
    check(rd[15:1] == 2 && !rd[0], "R10 retry after watchdog", rd[15:1], 2);
    check(!tgt_boot_sel, "R13 boot select follows control", tgt_boot_sel, 0);
    reg_wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule